// File: doc/BRIEF.md
# Serial Switch-Enable Shift and Hold Register

This block holds the control word for a bank of independent switches. A serial bit stream is shifted into a multi-stage register on each rising edge of the shift clock. A bank of level-sensitive hold latches passes that register to the switch-enable outputs, or keeps the outputs frozen. A hold input selects between the two. The last register stage is also brought out as a serial output, so that several blocks can be chained on one data line.

The hold input is driven high before a new word is shifted in. The switches then keep their previous state while the register fills. The hold input is then pulsed low to load the new word into the latches. An asynchronous, active-high clear input empties both the register and the latches, which turns every switch off.

Top module: `swc_serial_hold`

## Requirements
- R1: On each rising edge of `shift_clk`, when `clear` is low, stage 0 of the shift register takes `ser_in` and every stage k (k ≥ 1) takes the old value of stage k-1.
- R2: The register is `CHANNELS` bits wide (default 16), and bit k of the latch bank drives `sw_en[k]` alone. Each channel is controlled independently.
- R3: While `hold` is low and `clear` is low, `sw_en` equals the shift register contents.
- R4: While `hold` is high, `sw_en` keeps the value it had when `hold` rose, whatever is shifted in.
- R5: `ser_out` is 1 exactly when the last stage (bit `CHANNELS-1`) of the shift register holds a 1, whatever the level of `hold`.
- R6: `clear` high overrides `shift_clk`, `ser_in` and `hold`: the register and the latches stay at zero while `clear` is high.
- R7: `clear` acts asynchronously. `sw_en` becomes all zeros and `ser_out` becomes 0 without a clock edge.
- R8: The first bit shifted in after a clear reaches bit `CHANNELS-1` after `CHANNELS` rising edges, and it then drives `sw_en[CHANNELS-1]`.
- R9: After reset (clear asserted), every `sw_en` bit is 0 and `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Serial shift clock, rising-edge active |
| clear | input | 1 | Asynchronous active-high clear of register and latches |
| ser_in | input | 1 | Serial data into stage 0 |
| hold | input | 1 | Low: latches transparent. High: latches hold their value |
| sw_en | output | CHANNELS | Switch-enable outputs, one per channel |
| ser_out | output | 1 | Last shift stage, for chaining |

## Verification
The bench drives a pseudo-random stream through the register with the hold input open and compares every stage with an arithmetic shift model. A design that reversed the shift direction, or skipped a stage, would show the wrong word at once. With the hold input high, further clocking must leave the outputs frozen while the serial output keeps tracking the register. A latch that leaked would pick up the new bits. A clear asserted between clock edges must zero everything before the next edge, which a synchronous clear would miss. A single marker bit followed by zeros must land on the top channel after exactly `CHANNELS` edges, which exposes an off-by-one depth.

// File: rtl/swc_pkg.sv
package swc_pkg;
   localparam int unsigned SWC_DEF_CHANNELS = 16;
   localparam int unsigned SWC_MIN_CHANNELS = 2;

   function automatic logic swc_tail(input logic [63:0] word, input int unsigned n);
      return word[n-1];
   endfunction
endpackage

// File: rtl/swc_shift_chain.sv
module swc_shift_chain #(
   parameter int unsigned CHANNELS = swc_pkg::SWC_DEF_CHANNELS
) (
   input  logic                shift_clk,
   input  logic                clear,
   input  logic                ser_in,
   output logic [CHANNELS-1:0] stages
);
   localparam int unsigned TOP = CHANNELS - 1;

   generate
      if (CHANNELS < swc_pkg::SWC_MIN_CHANNELS) begin : g_bad_width
         $error("swc_shift_chain: CHANNELS must be at least 2");
      end
   endgenerate

   always_ff @(posedge shift_clk or posedge clear) begin
      if (clear) stages <= '0;
      else       stages <= {stages[TOP-1:0], ser_in};
   end

   AST_SHIFT_MOVE: assert property (@(posedge shift_clk) disable iff (clear)
      $past(!clear) |-> stages[TOP:1] == $past(stages[TOP-1:0]))
      else $error("shift move"); // R1

   AST_SHIFT_LOAD: assert property (@(posedge shift_clk) disable iff (clear)
      $past(!clear) |-> stages[0] == $past(ser_in))
      else $error("shift load"); // R1
endmodule

// File: rtl/swc_hold_bank.sv
module swc_hold_bank #(
   parameter int unsigned CHANNELS = swc_pkg::SWC_DEF_CHANNELS
) (
   input  logic                shift_clk,
   input  logic                clear,
   input  logic                hold,
   input  logic [CHANNELS-1:0] d,
   output logic [CHANNELS-1:0] q
);
   generate
      for (genvar k = 0; k < CHANNELS; k++) begin : g_cell
         always_latch begin
            if (clear)      q[k] <= 1'b0;
            else if (!hold) q[k] <= d[k];
         end
      end
   endgenerate

   AST_HOLD_FROZEN: assert property (@(posedge shift_clk) disable iff (clear)
      (hold && $past(hold) && $past(!clear)) |-> $stable(q))
      else $error("hold leak"); // R4

   AST_CLEAR_WINS: assert property (@(posedge shift_clk)
      clear |-> q == '0)
      else $error("clear lost"); // R6
endmodule

// File: rtl/swc_serial_hold.sv
module swc_serial_hold #(
   parameter int unsigned CHANNELS = swc_pkg::SWC_DEF_CHANNELS
) (
   input  logic                shift_clk,
   input  logic                clear,
   input  logic                ser_in,
   input  logic                hold,
   output logic [CHANNELS-1:0] sw_en,
   output logic                ser_out
);
   localparam int unsigned TOP = CHANNELS - 1;

   generate
      if (CHANNELS > 64) begin : g_too_wide
         $error("swc_serial_hold: CHANNELS above 64 not supported");
      end
   endgenerate

   logic [CHANNELS-1:0] chain_q;

   swc_shift_chain #(.CHANNELS(CHANNELS)) u_chain (
      .shift_clk (shift_clk),
      .clear     (clear),
      .ser_in    (ser_in),
      .stages    (chain_q)
   );

   swc_hold_bank #(.CHANNELS(CHANNELS)) u_bank (
      .shift_clk (shift_clk),
      .clear     (clear),
      .hold      (hold),
      .d         (chain_q),
      .q         (sw_en)
   );

   assign ser_out = chain_q[TOP];

   AST_OPEN_FOLLOW: assert property (@(negedge shift_clk) disable iff (clear)
      !hold |-> sw_en == chain_q)
      else $error("open latch mismatch"); // R3

   AST_TAIL_MATCH: assert property (@(negedge shift_clk) disable iff (clear)
      !hold |-> ser_out == sw_en[TOP])
      else $error("tail mismatch"); // R5
endmodule

// File: tb/tb_swc_serial_hold.sv
module tb_swc_serial_hold;
   localparam int unsigned N = 16;

   logic          shift_clk = 1'b0;
   logic          clear = 1'b1;
   logic          ser_in = 1'b0;
   logic          hold = 1'b0;
   logic [N-1:0]  sw_en;
   logic          ser_out;

   int n_checks = 0;
   int n_fails  = 0;
   logic [N-1:0] m_sr  = '0;
   logic [N-1:0] m_lat = '0;
   logic [15:0]  lfsr  = 16'hACE1;
   bit           done  = 1'b0;

   swc_serial_hold #(.CHANNELS(N)) dut (
      .shift_clk (shift_clk),
      .clear     (clear),
      .ser_in    (ser_in),
      .hold      (hold),
      .sw_en     (sw_en),
      .ser_out   (ser_out)
   );

   always #10 shift_clk = ~shift_clk;

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bit per rising edge; model updated, outputs sampled 5 ns after the edge
   task automatic push(input logic b);
      ser_in = b;
      @(posedge shift_clk);
      m_sr = {m_sr[N-2:0], b};
      if (!hold) m_lat = m_sr;
      #5;
   endtask

   task automatic look(input string tag);
      chk({tag, " sw_en"}, sw_en, m_lat);
      chk({tag, " ser_out"}, {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_sr[N-1]});
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R9 reset state under clear
      @(posedge shift_clk); #5;
      chk("R9 reset sw_en", sw_en, '0);
      chk("R9 reset ser_out", {{(N-1){1'b0}}, ser_out}, '0);
      // R6 clear overrides: toggle inputs while clear is high
      ser_in = 1'b1; hold = 1'b0;
      @(posedge shift_clk); #5;
      chk("R6 clear override", sw_en, '0);
      clear = 1'b0;

      // R1 R2 R3 R5 transparent sweep with pseudo-random stream
      for (int i = 0; i < 200; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         push(lfsr[0]);
         look("R3 R1 open");
      end

      // R4 R5 hold: outputs frozen while register keeps shifting
      hold = 1'b1;
      for (int i = 0; i < 40; i++) begin
         push(i[0] ^ i[2]);
         look("R4 R5 held");
      end
      // reopen: outputs jump to register
      hold = 1'b0; m_lat = m_sr; #1;
      chk("R3 reopen", sw_en, m_sr);

      // R7 asynchronous clear between edges, held over an edge
      hold = 1'b1;
      @(negedge shift_clk); #2;
      clear = 1'b1; #1;
      m_sr = '0; m_lat = '0;
      chk("R7 async sw_en", sw_en, '0);
      chk("R7 async ser_out", {{(N-1){1'b0}}, ser_out}, '0);
      @(posedge shift_clk); #5;
      clear = 1'b0; hold = 1'b0;

      // R8 marker reaches top channel after N edges
      push(1'b1);
      for (int i = 1; i < N; i++) begin
         chk("R8 marker not yet at top", {{(N-1){1'b0}}, ser_out}, '0);
         push(1'b0);
      end
      chk("R8 marker at top", sw_en, {1'b1, {(N-1){1'b0}}});
      chk("R5 marker ser_out", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, 1'b1});

      // R2 independence: each single channel alone
      for (int c = 0; c < N; c++) begin
         for (int j = 0; j < N; j++) push((N-1-j) == c);
         chk("R2 single channel", sw_en, N'(1) << c);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule